// File: doc/BRIEF.md
# Two-Port Shared-Word Contention Arbiter

This block sits in front of a memory that two independent ports can reach in the same clock cycle. On every cycle it compares the two port addresses and enables. When both ports are active on the same word, it decides which port keeps the word. The port that loses is told through an active-low busy flag. The same decision gates the per-port write strobes, so the losing port cannot change the contested word. Read traffic is never gated.

A static mode input sets the role of the block. As the master, it arbitrates and drives the decision out on its busy pins. As a slave, it does no arbitration of its own. It takes the busy flags of a master as inputs and uses them only to hold back writes. Several devices of this kind can then share one decision and form a wider word.

The block carries no data, so it has no valid/ready stream interface. Every pin is a plain level that is sampled on the rising clock edge. The mode may change only while reset is asserted.

Top module: `dpa_contention_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both busy outputs are high (deasserted).
- R2: In master mode a busy output goes low only in the cycle after one in which both enables were high and the two addresses were equal.
- R3: In master mode, suppose one port has been active on an address for at least one cycle and the other, already enabled, moves its address onto it. The port that moved gets busy low one cycle later.
- R4: In master mode, suppose the addresses already match and one port is enabled. If the other port then raises its enable, the late port gets busy low one cycle later.
- R5: In master mode, when both ports reach the same word in the same cycle and neither was on it before, the left port wins and only the right busy goes low.
- R6: In master mode, busy is never low on both sides. Every cycle of contention gives exactly one low busy in the following cycle.
- R7: Busy returns high one cycle after the addresses differ or either enable drops.
- R8: In master mode, a write is passed through only when its port is enabled, its write strobe is high and it is not the current loser. The loser's qualified write is low in the same cycle the contention is seen.
- R9: In slave mode both busy outputs stay high. Each qualified write equals enable AND write strobe AND the matching busy input, where a low busy input blocks the write.
- R10: Contention in which neither port writes still raises busy on the losing side.
- R11: While contention lasts without a break, the winner stays the same, whatever the write strobes do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = follow busy inputs |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in_n | input | 1 | Left busy from a master (slave mode), active low |
| r_busy_in_n | input | 1 | Right busy from a master (slave mode), active low |
| l_busy_n | output | 1 | Left busy flag, active low, registered |
| r_busy_n | output | 1 | Right busy flag, active low, registered |
| l_wr_ok | output | 1 | Qualified left write enable |
| r_wr_ok | output | 1 | Qualified right write enable |

## Verification
The hardest case to reach is the choice of winner when contention starts. That choice depends on what each port did in the previous cycle, not only on the present inputs. The stimulus therefore sweeps every pair of consecutive cycles over a two-bit address space, covering every address and enable combination for each port in both cycles. Address arrival, enable arrival, same-cycle arrival, continuing contention and release all follow from one another in every order. A separate sweep in slave mode walks all combinations of the busy inputs, enables and write strobes.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/dpa_match.sv
// Detects same-word contention and whether each port was already parked
// on its present address in the previous cycle.
module dpa_match #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              hit,
  output logic              l_stay,
  output logic              r_stay
);
  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;

  assign hit    = l_en & r_en & (l_addr == r_addr);
  assign l_stay = l_en_q & l_en & (l_addr == l_addr_q);
  assign r_stay = r_en_q & r_en & (r_addr == r_addr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end
endmodule

// File: rtl/dpa_arbiter.sv
// Picks the owner of a contested word and registers the busy flags.
module dpa_arbiter
  import dpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic hit,
  input  logic l_stay,
  input  logic r_stay,
  output logic lose_l,
  output logic lose_r,
  output logic busy_l_n,
  output logic busy_r_n
);
  logic  hit_q;
  side_e win_q;
  side_e win_now;

  // Continuing contention keeps the owner; a new one favours the port that
  // was already there, and a tie goes to the left port.
  always_comb begin
    if (hit_q)                 win_now = win_q;
    else if (r_stay && !l_stay) win_now = SIDE_RIGHT;
    else                        win_now = SIDE_LEFT;
  end

  assign lose_l = hit & (win_now == SIDE_RIGHT);
  assign lose_r = hit & (win_now == SIDE_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      win_q    <= SIDE_LEFT;
      busy_l_n <= 1'b1;
      busy_r_n <= 1'b1;
    end else begin
      hit_q    <= hit;
      if (hit) win_q <= win_now;
      busy_l_n <= ~(master_mode & lose_l);
      busy_r_n <= ~(master_mode & lose_r);
    end
  end
endmodule

// File: rtl/dpa_wr_gate.sv
// Qualifies one port's write strobe with the local or external decision.
module dpa_wr_gate (
  input  logic master_mode,
  input  logic en,
  input  logic wr,
  input  logic lose,
  input  logic ext_busy_n,
  output logic wr_ok
);
  logic allow;
  assign allow = master_mode ? ~lose : ext_busy_n;
  assign wr_ok = en & wr & allow;
endmodule

// File: rtl/dpa_contention_arbiter.sv
module dpa_contention_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  logic hit, l_stay, r_stay, lose_l, lose_r;
  logic [NUM_PORTS-1:0] p_en, p_wr, p_lose, p_ext, p_ok;

  dpa_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
    .hit(hit), .l_stay(l_stay), .r_stay(r_stay)
  );

  dpa_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .hit(hit), .l_stay(l_stay), .r_stay(r_stay),
    .lose_l(lose_l), .lose_r(lose_r),
    .busy_l_n(l_busy_n), .busy_r_n(r_busy_n)
  );

  assign p_en   = {r_en, l_en};
  assign p_wr   = {r_wr, l_wr};
  assign p_lose = {lose_r, lose_l};
  assign p_ext  = {r_busy_in_n, l_busy_in_n};

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_gate
    dpa_wr_gate u_gate (
      .master_mode(master_mode), .en(p_en[g]), .wr(p_wr[g]),
      .lose(p_lose[g]), .ext_busy_n(p_ext[g]), .wr_ok(p_ok[g])
    );
  end

  assign l_wr_ok = p_ok[SIDE_LEFT];
  assign r_wr_ok = p_ok[SIDE_RIGHT];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_ok
);
  logic same;
  assign same = l_en && r_en && (l_addr == r_addr);

  // R6
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> $past(master_mode && same));

  // R5
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && same && !$past(l_en) && !$past(r_en)) |=> (l_busy_n && !r_busy_n));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !same |=> (l_busy_n && r_busy_n));

  // R8
  loser_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n && same && $past(same)) |-> !l_wr_ok);

  // R9
  slave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !l_busy_in_n) |-> !l_wr_ok);

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |=> (l_busy_n && r_busy_n));
endmodule

bind dpa_contention_arbiter dpa_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
  .l_busy_in_n(l_busy_in_n), .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_ok(l_wr_ok)
);

// File: tb/tb_dpa_contention_arbiter.sv
module tb_dpa_contention_arbiter;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 0, l_wr = 0, r_en = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in_n = 1, r_busy_in_n = 1;
  logic l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit m_hit_q, m_win_r, pl_en, pr_en;
  logic [AW-1:0] pl_a, pr_a;

  always #10 clk = ~clk;

  dpa_contention_arbiter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 0; master_mode = mode;
    l_en = 0; r_en = 0; l_wr = 0; r_wr = 0; l_addr = '0; r_addr = '0;
    l_busy_in_n = 1; r_busy_in_n = 1;
    @(posedge clk); #2;
    check("R1", "l_busy_n in reset", l_busy_n, 1'b1);
    check("R1", "r_busy_n in reset", r_busy_n, 1'b1);
    @(negedge clk); rst_n = 1;
    m_hit_q = 0; m_win_r = 0; pl_en = 0; pr_en = 0; pl_a = '0; pr_a = '0;
    @(posedge clk); #2;
    check("R1", "l_busy_n after reset", l_busy_n, 1'b1);
    check("R1", "r_busy_n after reset", r_busy_n, 1'b1);
  endtask

  task automatic mstep(input bit le, input bit lw, input logic [AW-1:0] la,
                       input bit re, input bit rw, input logic [AW-1:0] ra);
    bit hit, ls, rs, winr, lose_l, lose_r;
    string tag;
    @(negedge clk);
    l_en = le; l_wr = lw; l_addr = la; r_en = re; r_wr = rw; r_addr = ra;
    hit  = le && re && (la == ra);
    ls   = pl_en && le && (la == pl_a);
    rs   = pr_en && re && (ra == pr_a);
    winr = m_hit_q ? m_win_r : (rs && !ls);
    lose_l = hit && winr;
    lose_r = hit && !winr;
    #2;
    check("R8", "l_wr_ok", l_wr_ok, le && lw && !lose_l);
    check("R8", "r_wr_ok", r_wr_ok, re && rw && !lose_r);
    if (!hit)              tag = m_hit_q ? "R7" : "R2";
    else if (m_hit_q)      tag = "R11";
    else if (!lw && !rw)   tag = "R10";
    else if (!ls && !rs)   tag = "R5";
    else if (winr)         tag = pl_en ? "R3" : "R4";
    else                   tag = pr_en ? "R3" : "R4";
    @(posedge clk); #2;
    check(tag, "l_busy_n", l_busy_n, !lose_l);
    check(tag, "r_busy_n", r_busy_n, !lose_r);
    if (hit) check("R6", "exactly one busy", l_busy_n ^ r_busy_n, 1'b1);
    m_hit_q = hit;
    if (hit) m_win_r = winr;
    pl_en = le; pr_en = re; pl_a = la; pr_a = ra;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // directed: right parks, left arrives by address (R3)
    mstep(0,0,2'd0, 1,1,2'd2);
    mstep(1,1,2'd1, 1,1,2'd2);
    mstep(1,1,2'd2, 1,1,2'd2);
    mstep(1,0,2'd2, 1,1,2'd2);   // R11 continuing
    mstep(1,1,2'd3, 1,1,2'd2);   // R7 address release
    // enable arrival (R4), then enable drop release (R7)
    mstep(1,1,2'd1, 0,0,2'd1);
    mstep(1,1,2'd1, 1,1,2'd1);
    mstep(1,1,2'd1, 0,1,2'd1);
    // simultaneous arrival (R5), read-only (R10)
    mstep(0,0,2'd0, 0,0,2'd0);
    mstep(1,1,2'd3, 1,1,2'd3);
    mstep(0,0,2'd0, 0,0,2'd0);
    mstep(1,0,2'd2, 1,0,2'd2);
    // reset in the middle of contention (R1)
    do_reset(1'b1);
    // exhaustive two-cycle sweep
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] v;
      v = 12'(i);
      mstep(v[4], v[0] ^ v[5], v[1:0], v[5], v[3] | v[4], v[3:2]);
      mstep(v[10], v[6] ^ v[11], v[7:6], v[11], v[9] ^ v[2], v[9:8]);
    end
    // slave mode sweep (R9)
    do_reset(1'b0);
    for (int j = 0; j < 64; j++) begin
      logic [5:0] s;
      s = 6'(j);
      @(negedge clk);
      l_en = s[0]; l_wr = s[1]; r_en = s[2]; r_wr = s[3];
      l_busy_in_n = s[4]; r_busy_in_n = s[5];
      l_addr = 2'd1; r_addr = 2'd1;
      #2;
      check("R9", "slave l_wr_ok", l_wr_ok, s[0] & s[1] & s[4]);
      check("R9", "slave r_wr_ok", r_wr_ok, s[2] & s[3] & s[5]);
      @(posedge clk); #2;
      check("R9", "slave l_busy_n", l_busy_n, 1'b1);
      check("R9", "slave r_busy_n", r_busy_n, 1'b1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule